// File: doc/BRIEF.md
# Grouped Radix-2 Delay-Feedback Butterfly Stage

This block is the opening radix-2 stage of a 128-point pipelined transform that carries four independent complex streams at once, one stream per lane. Each valid input cycle delivers one sample of every stream, and all four lanes share the same time index. Over a frame of 128 valid cycles, the sample at index n is combined with the sample at index n+64. In units of four-cycle groups, this pairs group g with group g+16.

During the first half of a frame, the incoming samples are parked in a feedback store of four banks, one bank per lane, 64 words each, 256 complex words in total. During the second half, four butterflies each take one operand from the store and one from the input. The sums leave at once. The differences are written back into the same addresses and leave during the first half of the next frame, while that frame refills the store.

Every difference must be rotated by the twiddle W128^a, where a is the pair index. Only two complex multipliers exist, and both work on every active cycle. In the butterfly half, they rotate lanes 0 and 1 before those lanes are stored. In the fill half, they rotate lanes 2 and 3 as those lanes are read out. The twiddles are rebuilt from a 17-entry table that covers one eighth of a period.

A short-transform mode lets the data pass through untouched, for the 64-point configuration.

Top module: `dfb_radix2_stage`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_is_dif`, `out_idx`, `out_re` and `out_im` are all zero.
- R2: On the valid cycle whose frame position p is in 64..127 (a = p-64), each lane outputs x[a]+x[a+64] exactly, as a 13-bit signed value. It also outputs `out_is_dif`=0 and `out_idx`=a. The output is registered and appears one clock after the input.
- R3: On frame position a in 0..63 of the next frame, each lane outputs the difference x[a]-x[a+64] multiplied by W = round(256·cos(2πa/128)) − j·round(256·sin(2πa/128)). The product is rounded by adding 128 and shifting right arithmetically by 8. The flags are `out_is_dif`=1 and `out_idx`=a.
- R4: Lanes are independent streams. Lane l of the output depends only on lane l of the input, and all lanes use the same twiddle in a given cycle.
- R5: After reset, the first 64 valid cycles of the first frame produce `out_valid`=0. Frame position advances only on valid cycles and wraps from 127 to 0.
- R6: The twiddle of every index has magnitude 256 within quantisation error, so an impulse difference of amplitude 1000 leaves with squared magnitude within 12000 of 1000000.
- R7: A cycle with `in_valid`=0 gives `out_valid`=0 on the next clock. It neither advances the frame position nor alters stored data.
- R8: With `short_mode`=1, a valid input appears one clock later, sign-extended to 13 bits, with `out_is_dif`=0 and `out_idx`=0. Any cycle in this mode discards the frame position and the stored half, so the next long-mode frame starts at position 0 with its fill half silent.
- R9: A rotated difference that exceeds the 13-bit range saturates to 4095 or −4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| short_mode | input | 1 | 1 = pass data through (64-point configuration) |
| in_valid | input | 1 | Input samples valid this cycle |
| in_re | input | 48 | Real parts, lane l at bits [12l+11:12l], signed |
| in_im | input | 48 | Imaginary parts, same packing |
| out_valid | output | 1 | Output samples valid |
| out_is_dif | output | 1 | 1 = rotated difference, 0 = sum or pass-through |
| out_idx | output | 6 | Pair index a of the output |
| out_re | output | 52 | Real parts, lane l at bits [13l+12:13l], signed |
| out_im | output | 52 | Imaginary parts, same packing |

## Verification
A corrupted word in the feedback store stays hidden for a while. It shows up as a wrong sum within the same frame, or as a wrong rotated difference one full frame later. The bench therefore keeps its own copy of each half-frame and checks every lane of every valid cycle across consecutive frames. A frame counter that slips shows at once as a wrong `out_idx` or a wrong `out_valid` at the half boundary. A wrong multiplier assignment or a wrong twiddle octant shows in the very next difference word. Impulse frames expose each of the 64 twiddles directly, and full-scale frames drive the rotation into saturation.

// File: rtl/fbr2_pkg.sv
package fbr2_pkg;

  typedef enum logic {PH_FILL = 1'b0, PH_BFLY = 1'b1} phase_e;

  localparam int TW_FRAC = 8;

  // cos(2*pi*q/128) * 256, rounded, for q = 0..16 (one eighth of a turn)
  function automatic int eighth_cos(input int q);
    case (q)
      0: return 256;  1: return 256;  2: return 255;  3: return 253;
      4: return 251;  5: return 248;  6: return 245;  7: return 241;
      8: return 237;  9: return 231; 10: return 226; 11: return 220;
      12: return 213; 13: return 206; 14: return 198; 15: return 190;
      default: return 181;
    endcase
  endfunction

  // sin(2*pi*q/128) * 256, rounded, for q = 0..16
  function automatic int eighth_sin(input int q);
    case (q)
      0: return 0;    1: return 13;   2: return 25;   3: return 38;
      4: return 50;   5: return 62;   6: return 74;   7: return 86;
      8: return 98;   9: return 109; 10: return 121; 11: return 132;
      12: return 142; 13: return 152; 14: return 162; 15: return 172;
      default: return 181;
    endcase
  endfunction

endpackage

// File: rtl/fbr2_twiddle.sv
module fbr2_twiddle
  import fbr2_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TW_W  = 10
) (
  input  logic [IDX_W-1:0]       idx,
  output logic signed [TW_W-1:0] w_re,
  output logic signed [TW_W-1:0] w_im
);
  localparam int OCT = 1 << (IDX_W - 2);

  logic [1:0]       oct;
  logic [IDX_W-3:0] r;
  int               rc;
  int               cv;
  int               sv;

  // Fold the half-turn index onto the stored eighth-wave using symmetry.
  always_comb begin
    oct = idx[IDX_W-1 -: 2];
    r   = idx[IDX_W-3:0];
    rc  = OCT - int'(r);
    case (oct)
      2'd0: begin cv =  eighth_cos(int'(r)); sv = eighth_sin(int'(r)); end
      2'd1: begin cv =  eighth_sin(rc);      sv = eighth_cos(rc);      end
      2'd2: begin cv = -eighth_sin(int'(r)); sv = eighth_cos(int'(r)); end
      default: begin cv = -eighth_cos(rc);   sv = eighth_sin(rc);      end
    endcase
    w_re = TW_W'(cv);
    w_im = TW_W'(-sv);
  end

  // R6: every rebuilt twiddle lies on the unit circle within rounding error
  always_comb begin
    p_tw_mag_r6: assert ((cv * cv + sv * sv > 65536 - 600) && (cv * cv + sv * sv < 65536 + 600))
      else $error("twiddle magnitude off at index %0d", idx);
  end

endmodule

// File: rtl/fbr2_cmul.sv
module fbr2_cmul
  import fbr2_pkg::*;
#(
  parameter int D_W  = 13,
  parameter int T_W  = 10,
  parameter int FRAC = TW_FRAC
) (
  input  logic signed [D_W-1:0] a_re,
  input  logic signed [D_W-1:0] a_im,
  input  logic signed [T_W-1:0] w_re,
  input  logic signed [T_W-1:0] w_im,
  output logic signed [D_W-1:0] p_re,
  output logic signed [D_W-1:0] p_im
);
  localparam int P_W = D_W + T_W + 1;
  localparam int HI  = (1 << (D_W - 1)) - 1;
  localparam int LO  = -(1 << (D_W - 1));

  // Round half up, drop FRAC bits, clamp into D_W bits (R9).
  function automatic logic signed [D_W-1:0] fit(input logic signed [P_W-1:0] v);
    logic signed [P_W-1:0] t;
    t = (v + P_W'(1 << (FRAC - 1))) >>> FRAC;
    if (t > P_W'(HI))      return D_W'(HI);
    else if (t < P_W'(LO)) return D_W'(LO);
    else                   return t[D_W-1:0];
  endfunction

  logic signed [P_W-1:0] xr, xi, yr, yi, sr, si;

  assign xr = a_re;
  assign xi = a_im;
  assign yr = w_re;
  assign yi = w_im;
  assign sr = xr * yr - xi * yi;
  assign si = xr * yi + xi * yr;
  assign p_re = fit(sr);
  assign p_im = fit(si);

endmodule

// File: rtl/fbr2_bank.sv
module fbr2_bank #(
  parameter int D_W   = 13,
  parameter int A_W   = 6,
  parameter int DEPTH = 1 << A_W
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [A_W-1:0]        addr,
  input  logic signed [D_W-1:0] wd_re,
  input  logic signed [D_W-1:0] wd_im,
  output logic signed [D_W-1:0] rd_re,
  output logic signed [D_W-1:0] rd_im
);
  logic [2*D_W-1:0] mem [DEPTH];

  // Read the old word and write the new one at the same address each cycle.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= {wd_re, wd_im};
  end

  assign rd_re = mem[addr][2*D_W-1:D_W];
  assign rd_im = mem[addr][D_W-1:0];

endmodule

// File: rtl/dfb_radix2_stage.sv
module dfb_radix2_stage
  import fbr2_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IN_W  = 12,
  parameter int TW_W  = 10,
  parameter int HALF  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     short_mode,
  input  logic                     in_valid,
  input  logic [LANES*IN_W-1:0]    in_re,
  input  logic [LANES*IN_W-1:0]    in_im,
  output logic                     out_valid,
  output logic                     out_is_dif,
  output logic [$clog2(HALF)-1:0]  out_idx,
  output logic [LANES*(IN_W+1)-1:0] out_re,
  output logic [LANES*(IN_W+1)-1:0] out_im
);
  localparam int A_W   = $clog2(HALF);
  localparam int CNT_W = A_W + 1;
  localparam int D_W   = IN_W + 1;
  localparam int NMUL  = LANES / 2;

  logic [CNT_W-1:0] cnt;
  logic             primed;
  phase_e           phase;
  logic [A_W-1:0]   pos;
  logic             act;
  logic             frame_end;

  assign phase     = phase_e'(cnt[CNT_W-1]);
  assign pos       = cnt[A_W-1:0];
  assign act       = in_valid & ~short_mode;
  assign frame_end = act & (cnt == CNT_W'(2 * HALF - 1));

  logic signed [TW_W-1:0] w_re, w_im;

  fbr2_twiddle #(.IDX_W(A_W), .TW_W(TW_W)) u_tw (
    .idx(pos), .w_re(w_re), .w_im(w_im)
  );

  logic signed [D_W-1:0] x_re [LANES], x_im [LANES];
  logic signed [D_W-1:0] m_re [LANES], m_im [LANES];
  logic signed [D_W-1:0] s_re [LANES], s_im [LANES];
  logic signed [D_W-1:0] d_re [LANES], d_im [LANES];
  logic signed [D_W-1:0] wd_re [LANES], wd_im [LANES];
  logic signed [D_W-1:0] nx_re [LANES], nx_im [LANES];
  logic signed [D_W-1:0] op_re [NMUL], op_im [NMUL];
  logic signed [D_W-1:0] pr_re [NMUL], pr_im [NMUL];

  // Two shared rotators: store path in the butterfly half, read path in the fill half.
  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    assign op_re[m] = (phase == PH_BFLY) ? d_re[m] : m_re[m + NMUL];
    assign op_im[m] = (phase == PH_BFLY) ? d_im[m] : m_im[m + NMUL];
    fbr2_cmul #(.D_W(D_W), .T_W(TW_W)) u_mul (
      .a_re(op_re[m]), .a_im(op_im[m]), .w_re(w_re), .w_im(w_im),
      .p_re(pr_re[m]), .p_im(pr_im[m])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign x_re[l] = D_W'(signed'(in_re[l*IN_W +: IN_W]));
    assign x_im[l] = D_W'(signed'(in_im[l*IN_W +: IN_W]));

    fbr2_bank #(.D_W(D_W), .A_W(A_W)) u_bank (
      .clk(clk), .we(act), .addr(pos),
      .wd_re(wd_re[l]), .wd_im(wd_im[l]),
      .rd_re(m_re[l]), .rd_im(m_im[l])
    );

    assign s_re[l] = m_re[l] + x_re[l];
    assign s_im[l] = m_im[l] + x_im[l];
    assign d_re[l] = m_re[l] - x_re[l];
    assign d_im[l] = m_im[l] - x_im[l];

    if (l < NMUL) begin : g_pre
      // rotated before storage, leaves as stored
      assign wd_re[l] = (phase == PH_BFLY) ? pr_re[l] : x_re[l];
      assign wd_im[l] = (phase == PH_BFLY) ? pr_im[l] : x_im[l];
      assign nx_re[l] = (phase == PH_BFLY) ? s_re[l] : m_re[l];
      assign nx_im[l] = (phase == PH_BFLY) ? s_im[l] : m_im[l];
    end else begin : g_post
      // stored raw, rotated on the way out
      assign wd_re[l] = (phase == PH_BFLY) ? d_re[l] : x_re[l];
      assign wd_im[l] = (phase == PH_BFLY) ? d_im[l] : x_im[l];
      assign nx_re[l] = (phase == PH_BFLY) ? s_re[l] : pr_re[l - NMUL];
      assign nx_im[l] = (phase == PH_BFLY) ? s_im[l] : pr_im[l - NMUL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      primed     <= 1'b0;
      out_valid  <= 1'b0;
      out_is_dif <= 1'b0;
      out_idx    <= '0;
      out_re     <= '0;
      out_im     <= '0;
    end else begin
      out_valid <= in_valid & (short_mode | (phase == PH_BFLY) | primed);
      if (short_mode) begin
        cnt    <= '0;
        primed <= 1'b0;
      end else if (in_valid) begin
        cnt <= cnt + 1'b1;
        if (frame_end) primed <= 1'b1;
      end
      if (in_valid) begin
        out_is_dif <= ~short_mode & (phase == PH_FILL);
        out_idx    <= short_mode ? '0 : pos;
        for (int l = 0; l < LANES; l++) begin
          out_re[l*D_W +: D_W] <= short_mode ? x_re[l] : nx_re[l];
          out_im[l*D_W +: D_W] <= short_mode ? x_im[l] : nx_im[l];
        end
      end
    end
  end

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && short_mode |=> out_valid && !out_is_dif && (out_re[D_W-1:0] == $past(x_re[0])));

  p_fill_silent_r5: assert property (@(posedge clk) disable iff (rst)
    act && (phase == PH_FILL) && !primed |=> !out_valid);

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> primed && (cnt == '0));

  p_sum_half_r2: assert property (@(posedge clk) disable iff (rst)
    act && (phase == PH_BFLY) |=> out_valid && !out_is_dif && (out_idx == $past(pos)));

endmodule

// File: tb/sim_dfb_radix2_stage.sv
`timescale 1ns/1ps
module sim_dfb_radix2_stage;
  localparam int LANES = 4;
  localparam int IN_W  = 12;
  localparam int D_W   = 13;
  localparam int HALF  = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, short_mode, in_valid;
  logic [LANES*IN_W-1:0] in_re, in_im;
  logic out_valid, out_is_dif;
  logic [5:0] out_idx;
  logic [LANES*D_W-1:0] out_re, out_im;

  dfb_radix2_stage u0 (
    .clk(clk), .rst(rst), .short_mode(short_mode), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_is_dif(out_is_dif),
    .out_idx(out_idx), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  int held_re [LANES][HALF], held_im [LANES][HALF];
  int pend_re [LANES][HALF], pend_im [LANES][HALF];
  int pend_pat [HALF];
  int cnt_m = 0;
  bit primed_m = 0;

  function automatic int gen(int pat, int fr, int c, int lane, int im);
    int h;
    case (pat)
      0: return (c < HALF && im == 0) ? 1000 : 0;
      1: return (c < HALF) ? 2047 : -2048;
      2: return ((c * 29 + lane * 300 + im * 700 + fr * 11) % 4096) - 2048;
      default: begin
        h = c * 37 + lane * 101 + im * 53 + fr * 211;
        return ((h * h * 7 + h * 13) % 4096) - 2048;
      end
    endcase
  endfunction

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int fitq(int p);
    int t;
    t = $rtoi($floor((real'(p) + 128.0) / 256.0));
    if (t > 4095) t = 4095;
    if (t < -4096) t = -4096;
    return t;
  endfunction

  function automatic int lane_val(logic [LANES*D_W-1:0] bus, int l);
    logic signed [D_W-1:0] t;
    t = bus[l*D_W +: D_W];
    return int'(t);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit s, int pat, int fr);
    int vr [LANES], vi [LANES], er [LANES], ei [LANES];
    int a, wr, wi, dr, di, src_pat, mag;
    bit ev, edif;
    int eidx;
    string tag, vtag;
    real ang;
    ev = 0; edif = 0; eidx = 0; tag = "R2"; src_pat = pat;
    for (int l = 0; l < LANES; l++) begin
      vr[l] = gen(pat, fr, cnt_m, l, 0);
      vi[l] = gen(pat, fr, cnt_m, l, 1);
      er[l] = 0; ei[l] = 0;
    end
    if (!v) vtag = s ? "R8" : "R7";
    else if (s) vtag = "R8";
    else vtag = "R5";
    if (s) begin
      if (v) begin
        ev = 1; tag = "R8";
        for (int l = 0; l < LANES; l++) begin er[l] = vr[l]; ei[l] = vi[l]; end
      end
      cnt_m = 0; primed_m = 0;
    end else if (v) begin
      a = cnt_m % HALF;
      eidx = a;
      if (cnt_m < HALF) begin
        ev = primed_m; edif = 1; tag = "R3"; src_pat = pend_pat[a];
        for (int l = 0; l < LANES; l++) begin
          er[l] = pend_re[l][a]; ei[l] = pend_im[l][a];
          held_re[l][a] = vr[l]; held_im[l][a] = vi[l];
        end
      end else begin
        ev = 1; edif = 0; tag = "R2";
        ang = 2.0 * 3.14159265358979 * real'(a) / 128.0;
        wr = rnd(256.0 * $cos(ang));
        wi = -rnd(256.0 * $sin(ang));
        for (int l = 0; l < LANES; l++) begin
          er[l] = held_re[l][a] + vr[l]; ei[l] = held_im[l][a] + vi[l];
          dr = held_re[l][a] - vr[l]; di = held_im[l][a] - vi[l];
          pend_re[l][a] = fitq(dr * wr - di * wi);
          pend_im[l][a] = fitq(dr * wi + di * wr);
        end
        pend_pat[a] = pat;
      end
      cnt_m++;
      if (cnt_m == 2 * HALF) begin cnt_m = 0; primed_m = 1; end
      if (src_pat == 3 || pat == 3) tag = "R4";
    end
    if (ev) vtag = tag;

    @(negedge clk);
    in_valid = v; short_mode = s;
    for (int l = 0; l < LANES; l++) begin
      in_re[l*IN_W +: IN_W] = vr[l][IN_W-1:0];
      in_im[l*IN_W +: IN_W] = vi[l][IN_W-1:0];
    end
    @(posedge clk); #1;

    chk(vtag, "out_valid", int'(out_valid), int'(ev));
    if (ev) begin
      chk(tag, "out_is_dif", int'(out_is_dif), int'(edif));
      chk(tag, "out_idx", int'(out_idx), eidx);
      for (int l = 0; l < LANES; l++) begin
        chk((er[l] == 4095 || er[l] == -4096) ? "R9" : tag, "re", lane_val(out_re, l), er[l]);
        chk((ei[l] == 4095 || ei[l] == -4096) ? "R9" : tag, "im", lane_val(out_im, l), ei[l]);
      end
      if (edif && src_pat == 0) begin
        mag = lane_val(out_re, 0) * lane_val(out_re, 0) + lane_val(out_im, 0) * lane_val(out_im, 0);
        chk("R6", "twiddle magnitude in tolerance", (mag > 1000000 - 12000 && mag < 1000000 + 12000) ? 1 : 0, 1);
      end
    end
  endtask

  task automatic frame(int pat, int fr, bit gaps);
    for (int c = 0; c < 2 * HALF; c++) begin
      if (gaps && (c % 7 == 3)) step(0, 0, pat, fr);
      step(1, 0, pat, fr);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    rst = 1; short_mode = 0; in_valid = 0; in_re = '0; in_im = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "out_re in reset", int'(out_re != '0), 0);
    chk("R1", "out_idx in reset", int'(out_idx), 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);

    frame(0, 0, 0);
    frame(1, 1, 0);
    frame(2, 2, 1);
    frame(3, 3, 0);
    frame(0, 4, 0);
    frame(3, 5, 0);
    for (int c = 0; c < 30; c++) step(1, 0, 2, 6);
    for (int i = 0; i < 20; i++) step(1, 1, 3, 7);
    step(0, 1, 3, 7);
    frame(3, 8, 0);
    frame(2, 9, 1);
    step(0, 0, 2, 10);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule